// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits in front of a small shared word memory that several processor ports reach at once. Each port can issue a plain load, a plain store, a linked load or a conditional store. A linked load returns the stored word and records the address in that port's reservation register with a valid flag. A later conditional store from the same port writes memory and reports success (status 1) only when that reservation is still intact and names the same address. Otherwise the conditional store reports 0 and memory keeps its contents.

The monitor watches every write from every port in every cycle. A write by any other port to a reserved address clears that reservation. Writes that collide in one cycle are settled by port number, and the lowest port goes first. Every request gets its response one clock later. Software builds atomic swap, fetch-and-add and lock loops on top of this by retrying failed conditional stores. Those loops live outside the block.

Top module: `llsc_monitor`

## Requirements
- R1: Reset clears all memory words to 0, drops every reservation and holds every `rspValid` bit low.
- R2: Opcode field `reqOp[2p+1:2p]` encodes 0 = load, 1 = store, 2 = linked load and 3 = conditional store. Port p's address and data sit at `reqAddr[p*ADDR_W +: ADDR_W]` and `reqData[p*DATA_W +: DATA_W]`. One clock after a request, `rspValid[p]` is 1 and, for a load or linked load, `rspData` carries the word held before that cycle's writes. For other opcodes `rspData` is 0.
- R3: A linked load reserves its address for the issuing port. A following conditional store from that port to the same address, with no write by another port to that address in between, returns status 1 and writes its data.
- R4: A failing conditional store returns status 0 and leaves memory unchanged.
- R5: A plain store, or a successful conditional store, by another port to a reserved address clears that reservation. Writes to other addresses leave it intact.
- R6: Every conditional store drops the issuing port's own reservation, whether it passes or fails.
- R7: A conditional store fails when its port holds no reservation, or when the reservation names a different address.
- R8: Loads from any port and the reserving port's own plain stores do not disturb a reservation.
- R9: Conditional stores to one address in one cycle pass only for the lowest-numbered eligible port. When several writes hit one address in one cycle, memory keeps the data of the lowest-numbered writer.
- R10: A linked load in the same cycle as another port's write to that address returns the old word and establishes no reservation.
- R11: `rspStatus[p]` can be 1 only in the response to a conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | NUM_PORTS | Request present, one bit per port |
| reqOp | input | 2*NUM_PORTS | Opcode per port |
| reqAddr | input | ADDR_W*NUM_PORTS | Word address per port |
| reqData | input | DATA_W*NUM_PORTS | Store data per port |
| rspValid | output | NUM_PORTS | Response present, one clock after request |
| rspData | output | DATA_W*NUM_PORTS | Read data per port |
| rspStatus | output | NUM_PORTS | Conditional store outcome, 1 = success |

## Verification
Every response (valid bit, read word and status) is due exactly one rising edge after its request. Memory and reservation effects become visible to the request issued in the next cycle. The bench drives a request on a falling edge and reads the response at the following falling edge, one full rising edge later. It checks the response against a requirement-derived model stepped at the same point. Directed sequences then probe written memory with a load that is itself checked one cycle later.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llscOp_e;

  // per-port strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic condPass;
  } portStrobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [2*NUM_PORTS-1:0]        reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0]   reqAddr,
  output portStrobe_t [NUM_PORTS-1:0]   strobe
);

  logic [ADDR_W-1:0] addrOf   [NUM_PORTS];
  llscOp_e           opOf     [NUM_PORTS];
  logic [ADDR_W-1:0] linkAddr [NUM_PORTS];
  logic [NUM_PORTS-1:0] linkValid;
  logic [NUM_PORTS-1:0] blockedVec;
  logic [NUM_PORTS-1:0] wrDone;
  logic [NUM_PORTS-1:0] passVec;
  logic [NUM_PORTS-1:0] hitLink;
  logic [NUM_PORTS-1:0] hitReq;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_unpack
    assign addrOf[g] = reqAddr[g*ADDR_W +: ADDR_W];
    assign opOf[g]   = llscOp_e'(reqOp[2*g +: 2]);
  end

  // write resolution in ascending port order: a lower port that writes
  // an address blocks any conditional store to it from higher ports
  always_comb begin
    wrDone     = '0;
    passVec    = '0;
    blockedVec = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q < p && wrDone[q] && addrOf[q] == addrOf[p]) blockedVec[p] = 1'b1;
      end
      passVec[p] = reqValid[p] && opOf[p] == OP_COND && linkValid[p] &&
                   linkAddr[p] == addrOf[p] && !blockedVec[p];
      wrDone[p]  = (reqValid[p] && opOf[p] == OP_STORE) || passVec[p];
    end
  end

  // snoop: writes by other ports against each reservation / each new link
  always_comb begin
    hitLink = '0;
    hitReq  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q != p && wrDone[q]) begin
          if (addrOf[q] == linkAddr[p]) hitLink[p] = 1'b1;
          if (addrOf[q] == addrOf[p])   hitReq[p]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= '0;
      for (int p = 0; p < NUM_PORTS; p++) linkAddr[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reqValid[p] && opOf[p] == OP_COND) begin
          linkValid[p] <= 1'b0;
        end else if (reqValid[p] && opOf[p] == OP_LINK) begin
          linkAddr[p]  <= addrOf[p];
          linkValid[p] <= !hitReq[p];
        end else if (hitLink[p]) begin
          linkValid[p] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobe[p].rdEn     = reqValid[p] && (opOf[p] == OP_LOAD || opOf[p] == OP_LINK);
      strobe[p].wrEn     = wrDone[p];
      strobe[p].condPass = passVec[p];
    end
  end

endmodule

// File: rtl/llsc_data.sv
module llsc_data
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [ADDR_W*NUM_PORTS-1:0]   reqAddr,
  input  logic [DATA_W*NUM_PORTS-1:0]   reqData,
  input  portStrobe_t [NUM_PORTS-1:0]   strobe,
  output logic [NUM_PORTS-1:0]          rspValid,
  output logic [DATA_W*NUM_PORTS-1:0]   rspData,
  output logic [NUM_PORTS-1:0]          rspStatus
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem    [DEPTH];
  logic [ADDR_W-1:0] addrOf [NUM_PORTS];
  logic [DATA_W-1:0] dataOf [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_unpack
    assign addrOf[g] = reqAddr[g*ADDR_W +: ADDR_W];
    assign dataOf[g] = reqData[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rspValid  <= '0;
      rspData   <= '0;
      rspStatus <= '0;
    end else begin
      // descending order: the lowest-numbered writer lands last and wins
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (strobe[p].wrEn) mem[addrOf[p]] <= dataOf[p];
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        rspValid[p]                 <= reqValid[p];
        rspData[p*DATA_W +: DATA_W] <= strobe[p].rdEn ? mem[addrOf[p]] : '0;
        rspStatus[p]                <= strobe[p].condPass;
      end
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [2*NUM_PORTS-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input  logic [DATA_W*NUM_PORTS-1:0] reqData,
  output logic [NUM_PORTS-1:0]        rspValid,
  output logic [DATA_W*NUM_PORTS-1:0] rspData,
  output logic [NUM_PORTS-1:0]        rspStatus
);

  portStrobe_t [NUM_PORTS-1:0] strobe;

  llsc_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .strobe(strobe)
  );

  llsc_data #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .strobe(strobe), .rspValid(rspValid),
    .rspData(rspData), .rspStatus(rspStatus)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        reqValid,
  input logic [2*NUM_PORTS-1:0]      reqOp,
  input logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input logic [NUM_PORTS-1:0]        rspValid,
  input logic [NUM_PORTS-1:0]        rspStatus
);

  // checker-side record: a linked load seen since the last conditional store
  logic [NUM_PORTS-1:0] llSeen;

  always_ff @(posedge clk) begin
    if (!rstN) llSeen <= '0;
    else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reqValid[p] && reqOp[2*p +: 2] == 2'd2) llSeen[p] <= 1'b1;
        else if (reqValid[p] && reqOp[2*p +: 2] == 2'd3) llSeen[p] <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
      rspValid[p] == $past(reqValid[p])); // R2
    AST_STATUS_ONLY_COND: assert property (@(posedge clk) disable iff (!rstN)
      rspStatus[p] |-> $past(reqValid[p] && reqOp[2*p +: 2] == 2'd3)); // R11
    AST_PASS_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rstN)
      rspStatus[p] |-> $past(llSeen[p])); // R7
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
        (rspStatus[p] && rspStatus[q]) |->
          $past(reqAddr[p*ADDR_W +: ADDR_W] != reqAddr[q*ADDR_W +: ADDR_W])); // R9
    end
  end

endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspStatus(rspStatus)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;

  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    reqValid;
  logic [2*NP-1:0]  reqOp;
  logic [AW*NP-1:0] reqAddr;
  logic [DW*NP-1:0] reqData;
  logic [NP-1:0]    rspValid;
  logic [DW*NP-1:0] rspData;
  logic [NP-1:0]    rspStatus;

  logic [NP-1:0] bValid;
  logic [1:0]    bOp   [NP];
  logic [AW-1:0] bAddr [NP];
  logic [DW-1:0] bData [NP];

  for (genvar g = 0; g < NP; g++) begin : g_pack
    assign reqValid[g]          = bValid[g];
    assign reqOp[2*g +: 2]      = bOp[g];
    assign reqAddr[g*AW +: AW]  = bAddr[g];
    assign reqData[g*DW +: DW]  = bData[g];
  end

  always #2.5 clk = ~clk;

  llsc_monitor #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .rspValid(rspValid), .rspData(rspData), .rspStatus(rspStatus)
  );

  int testCnt = 0;
  int failCnt = 0;

  // requirement-derived model state
  logic [DW-1:0] mMem  [DEPTH];
  logic          mLinkV[NP];
  logic [AW-1:0] mLinkA[NP];
  logic          expV  [NP];
  logic [DW-1:0] expD  [NP];
  logic          expS  [NP];

  task automatic checkEq(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic wr [NP];
    logic pass [NP];
    logic blk;
    for (int p = 0; p < NP; p++) begin
      expV[p] = bValid[p];
      expD[p] = (bValid[p] && (bOp[p] == 2'd0 || bOp[p] == 2'd2)) ? mMem[bAddr[p]] : '0;
      blk = 1'b0;
      for (int q = 0; q < p; q++) if (wr[q] && bAddr[q] == bAddr[p]) blk = 1'b1;
      pass[p] = bValid[p] && bOp[p] == 2'd3 && mLinkV[p] && mLinkA[p] == bAddr[p] && !blk;
      wr[p]   = (bValid[p] && bOp[p] == 2'd1) || pass[p];
      expS[p] = pass[p];
    end
    for (int p = 0; p < NP; p++) begin
      logic hitL, hitR;
      hitL = 1'b0; hitR = 1'b0;
      for (int q = 0; q < NP; q++) begin
        if (q != p && wr[q] && bAddr[q] == mLinkA[p]) hitL = 1'b1;
        if (q != p && wr[q] && bAddr[q] == bAddr[p])  hitR = 1'b1;
      end
      if (bValid[p] && bOp[p] == 2'd3) mLinkV[p] = 1'b0;
      else if (bValid[p] && bOp[p] == 2'd2) begin
        mLinkA[p] = bAddr[p];
        mLinkV[p] = !hitR;
      end else if (hitL) mLinkV[p] = 1'b0;
    end
    for (int p = NP - 1; p >= 0; p--) if (wr[p]) mMem[bAddr[p]] = bData[p];
  endtask

  task automatic compareAll();
    for (int p = 0; p < NP; p++) begin
      checkEq("R2", $sformatf("port%0d rspValid", p), {31'd0, rspValid[p]}, {31'd0, expV[p]});
      checkEq("R2", $sformatf("port%0d rspData", p), rspData[p*DW +: DW], expD[p]);
      checkEq(bOp[p] == 2'd3 ? "R3" : "R11", $sformatf("port%0d rspStatus", p),
              {31'd0, rspStatus[p]}, {31'd0, expS[p]});
    end
  endtask

  // inputs are set at a falling edge; responses read at the next falling edge
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) begin
      bValid[p] = 1'b0; bOp[p] = 2'd0; bAddr[p] = '0; bData[p] = '0;
    end
  endtask

  task automatic req(int p, logic [1:0] op, int a, logic [DW-1:0] d);
    bValid[p] = 1'b1; bOp[p] = op; bAddr[p] = AW'(a); bData[p] = d;
  endtask

  function automatic logic [DW-1:0] rd(int p);
    return rspData[p*DW +: DW];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5e_0a11));
    idle();
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    for (int p = 0; p < NP; p++) begin mLinkV[p] = 1'b0; mLinkA[p] = '0; end
    repeat (4) @(negedge clk);
    checkEq("R1", "rspValid in reset", {28'd0, rspValid}, '0);
    rstN = 1'b1;

    // R1: memory cleared, no reservation after reset
    idle(); req(1, 2'd0, 7, 0); req(0, 2'd3, 3, 32'hDEAD); step();
    checkEq("R1", "load after reset", rd(1), 32'h0);
    checkEq("R1", "cond store after reset", {31'd0, rspStatus[0]}, 32'd0);

    // R3 basic pair
    idle(); req(0, 2'd2, 2, 0); step();
    checkEq("R2", "linked load data", rd(0), 32'h0);
    idle(); req(0, 2'd3, 2, 32'hA5); step();
    checkEq("R3", "cond store pass", {31'd0, rspStatus[0]}, 32'd1);
    idle(); req(1, 2'd0, 2, 0); step();
    checkEq("R3", "written word", rd(1), 32'hA5);

    // R6 reservation consumed
    idle(); req(0, 2'd3, 2, 32'hBB); step();
    checkEq("R6", "second cond store", {31'd0, rspStatus[0]}, 32'd0);
    idle(); req(1, 2'd0, 2, 0); step();
    checkEq("R4", "memory kept", rd(1), 32'hA5);

    // R5 other-port store breaks link
    idle(); req(0, 2'd2, 4, 0); step();
    idle(); req(2, 2'd1, 4, 32'h11); step();
    idle(); req(0, 2'd3, 4, 32'h22); step();
    checkEq("R5", "link broken by store", {31'd0, rspStatus[0]}, 32'd0);
    idle(); req(3, 2'd0, 4, 0); step();
    checkEq("R4", "failed store no write", rd(3), 32'h11);

    // R5/R8: other address store and foreign load leave link
    idle(); req(1, 2'd2, 5, 0); step();
    idle(); req(2, 2'd1, 6, 32'h99); req(3, 2'd0, 5, 0); step();
    idle(); req(1, 2'd3, 5, 32'h33); step();
    checkEq("R8", "link survives load/other addr", {31'd0, rspStatus[1]}, 32'd1);

    // R8: own plain store keeps link
    idle(); req(0, 2'd2, 8, 0); step();
    idle(); req(0, 2'd1, 8, 32'h44); step();
    idle(); req(0, 2'd3, 8, 32'h55); step();
    checkEq("R8", "own store keeps link", {31'd0, rspStatus[0]}, 32'd1);

    // R7: address mismatch
    idle(); req(0, 2'd2, 9, 0); step();
    idle(); req(0, 2'd3, 10, 32'h66); step();
    checkEq("R7", "address mismatch", {31'd0, rspStatus[0]}, 32'd0);

    // R9: same-cycle conditional stores
    idle(); req(0, 2'd2, 1, 0); req(1, 2'd2, 1, 0); req(2, 2'd2, 1, 0); step();
    idle(); req(0, 2'd3, 1, 32'hC0); req(1, 2'd3, 1, 32'hC1); req(2, 2'd3, 1, 32'hC2); step();
    checkEq("R9", "port0 wins", {29'd0, rspStatus[2:0]}, 32'd1);
    idle(); req(3, 2'd0, 1, 0); step();
    checkEq("R9", "winner data", rd(3), 32'hC0);

    // R9: colliding plain stores
    idle(); req(1, 2'd1, 12, 32'h66); req(3, 2'd1, 12, 32'h77); step();
    idle(); req(0, 2'd0, 12, 0); step();
    checkEq("R9", "lowest writer data", rd(0), 32'h66);

    // R10: link and foreign write same cycle
    idle(); req(0, 2'd2, 13, 0); req(1, 2'd1, 13, 32'h88); step();
    checkEq("R10", "old word returned", rd(0), 32'h0);
    idle(); req(0, 2'd3, 13, 32'h89); step();
    checkEq("R10", "no reservation", {31'd0, rspStatus[0]}, 32'd0);

    // constrained random on a few hot addresses
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(9) < 7) req(p, 2'($urandom_range(3)), $urandom_range(3), $urandom);
      end
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule